// File: doc/BRIEF.md
# Dual-Clock Single-Bit FIFO with Programmable Threshold Flags

This block is a one-bit-wide first-in first-out buffer. The write side and the read side each run on their own clock, and the two clocks may be unrelated or may be the same net. Storage depth is a parameter; 64, 256 and 512 entries are the intended sizes. Four active-low status outputs report the fill level. Empty and almost-empty are produced in the read clock domain. Full and almost-full are produced in the write clock domain.

One write-side pin has two uses. The level it holds while reset is asserted fixes its meaning until the next reset. If it is high during reset, it acts as a second, active-high write qualifier. If it is low during reset, the block enters threshold-programming mode. In that mode the pin is an active-low load strobe: each load writes the byte on the offset bus into the next threshold slot of a fixed rotation. The two thresholds are n for almost-empty and m for almost-full.

Pointers cross between the clock domains as Gray code through flop chains. Each side computes its fill level from its own binary pointer and the synchronised pointer of the other side. The three-state output pad is modelled by a separate drive-enable output.

Top module: `serial_fifo_dc`

## Requirements
- R1: While `rst_n` is low, both pointers return to entry 0, `full_n` and `afull_n` are 1, `empty_n` and `aempty_n` are 0, and the output data register is cleared to 0.
- R2: The level of `wen_b_ld` at the write clock edges seen during reset selects the mode. 1 selects dual-enable mode. 0 selects programming mode. In dual-enable mode, `wen_a_n`=0 with `wen_b_ld`=0 changes no threshold.
- R3: In dual-enable mode, a bit is stored on a rising `wr_clk` only when `wen_a_n`=0 and `wen_b_ld`=1. Every other combination stores nothing.
- R4: In programming mode, `wen_a_n`=0 with `wen_b_ld`=1 stores a bit. `wen_a_n`=0 with `wen_b_ld`=0 loads a threshold byte and stores no bit.
- R5: A write request while `full_n`=0 is ignored, and a read request while `empty_n`=0 is ignored. Neither pointer moves, and the output register keeps its value.
- R6: On a rising `rd_clk` with `rd_en_n`=0 and `empty_n`=1, the oldest stored bit moves into the output register. With `rd_en_n`=1 the register holds. Bits leave in the order they were written.
- R7: `empty_n` is 0 exactly when the fill level is 0. `full_n` becomes 0 once DEPTH bits are held.
- R8: `aempty_n` is 0 while the fill level is between 0 and n, and 1 from n+1 upward. n resets to 7.
- R9: `afull_n` is 0 while the fill level is DEPTH−m or more. m resets to 7.
- R10: Each load writes the next slot in a fixed rotation: all bytes of n (low byte first), then all bytes of m, then back to n. For DEPTH=64 there is one byte per threshold, taken from `ofs_in[5:0]`. The rotation position survives intervals in which `wen_b_ld` is high.
- R11: `full_n` and `afull_n` fall on the same `wr_clk` edge that stores the bit reaching their threshold. A bit written into an empty buffer raises `empty_n` after one to three `rd_clk` edges, and never before a read edge.
- R12: `dout_en` equals the inverse of `oe_n`. While `oe_n`=1, `dout` is 0.
- R13: Each pointer's Gray value changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset shared by both sides |
| din | input | 1 | Serial data in |
| wen_a_n | input | 1 | Primary write enable, active low |
| wen_b_ld | input | 1 | Second write enable (high) or threshold load strobe (low), chosen at reset |
| ofs_in | input | 8 | Threshold byte to load |
| rd_en_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output drive enable, active low |
| dout | output | 1 | Serial data out, 0 while not driven |
| dout_en | output | 1 | High when `dout` would drive the pad |
| full_n | output | 1 | Full, active low, write domain |
| afull_n | output | 1 | Almost full, active low, write domain |
| empty_n | output | 1 | Empty, active low, read domain |
| aempty_n | output | 1 | Almost empty, active low, read domain |

## Verification
Read data sits behind one register, so it is valid on the read edge that accepts the request. The monitor therefore compares it a few nanoseconds after that edge. The local flags (`full_n` and `afull_n` on writes, `empty_n` and `aempty_n` on reads) change on the edge of the request itself, and the bench checks them just after that edge. A flag that depends on the other domain lags by the synchroniser depth: one to three destination edges. The bench waits four edges of each clock before judging such a flag, and it counts read edges explicitly to bound the lag of the empty flag after the first write.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   localparam int OFS_BYTE_W = 8;
   localparam int OFS_RESET  = 7;

   typedef enum logic {
      WMODE_DUAL_EN = 1'b0,
      WMODE_PROG    = 1'b1
   } wmode_e;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfifo_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sfifo_wport_cfg.sv
module sfifo_wport_cfg
   import sfifo_pkg::*;
#(
   parameter int OFS_W = 6
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wen_a_n,
   input  logic             wen_b_ld,
   input  logic [7:0]       ofs_in,
   output logic             prog_mode,
   output logic             wr_req,
   output logic [OFS_W-1:0] n_ofs,
   output logic [OFS_W-1:0] m_ofs
);
   localparam int LOADS = (OFS_W + OFS_BYTE_W - 1) / OFS_BYTE_W;
   localparam int SLOTS = 2 * LOADS;
   localparam int IW    = $clog2(SLOTS);
   localparam int PADW  = LOADS * OFS_BYTE_W;

   wmode_e          mode_q;
   logic            ld_fire;
   logic [IW-1:0]   slot_q;
   logic [7:0]      e_byte [LOADS];
   logic [7:0]      f_byte [LOADS];
   logic [PADW-1:0] e_pad;
   logic [PADW-1:0] f_pad;

   // mode is captured by the free-running write clock while reset is held
   always_ff @(posedge wr_clk) begin
      if (!rst_n) mode_q <= wen_b_ld ? WMODE_DUAL_EN : WMODE_PROG;
   end

   assign prog_mode = (mode_q == WMODE_PROG);
   assign wr_req    = !wen_a_n && wen_b_ld;
   assign ld_fire   = prog_mode && !wen_a_n && !wen_b_ld;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         for (int s = 0; s < LOADS; s++) begin
            e_byte[s] <= (s == 0) ? 8'(OFS_RESET) : 8'h00;
            f_byte[s] <= (s == 0) ? 8'(OFS_RESET) : 8'h00;
         end
      end else if (ld_fire) begin
         for (int s = 0; s < LOADS; s++) begin
            if (slot_q == IW'(s))         e_byte[s] <= ofs_in;
            if (slot_q == IW'(s + LOADS)) f_byte[s] <= ofs_in;
         end
         slot_q <= (slot_q == IW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end
   end

   for (genvar g = 0; g < LOADS; g++) begin : g_pack
      assign e_pad[g*OFS_BYTE_W +: OFS_BYTE_W] = e_byte[g];
      assign f_pad[g*OFS_BYTE_W +: OFS_BYTE_W] = f_byte[g];
   end

   assign n_ofs = e_pad[OFS_W-1:0];
   assign m_ofs = f_pad[OFS_W-1:0];

   if (PADW > OFS_W) begin : g_pad_sink
      logic unused_pad_hi;
      assign unused_pad_hi = ^{e_pad[PADW-1:OFS_W], f_pad[PADW-1:OFS_W]};
   end
endmodule

// File: rtl/sfifo_wr_ctl.sv
module sfifo_wr_ctl #(
   parameter int AW = 6
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [AW:0]   rgray_s,
   input  logic [AW-1:0] m_ofs,
   output logic [AW:0]   wgray,
   output logic [AW-1:0] waddr,
   output logic          wr_fire,
   output logic          full_n,
   output logic          afull_n
);
   localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};
   localparam logic [AW+1:0] FULL_EXT = {1'b0, FULL_CNT};

   logic [AW:0] wbin_q, wbin_nx, rbin_s, fill;

   always_comb begin
      rbin_s[AW] = rgray_s[AW];
      for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign fill    = wbin_q - rbin_s;
   assign full_n  = (fill != FULL_CNT);
   assign afull_n = (({1'b0, fill} + {2'b00, m_ofs}) < FULL_EXT);
   assign wr_fire = wr_req && full_n;
   assign wbin_nx = wbin_q + 1'b1;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q <= '0;
         wgray  <= '0;
      end else if (wr_fire) begin
         wbin_q <= wbin_nx;
         wgray  <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign waddr = wbin_q[AW-1:0];
endmodule

// File: rtl/sfifo_rd_ctl.sv
module sfifo_rd_ctl #(
   parameter int AW = 6
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en_n,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] n_ofs,
   input  logic          mem_bit,
   output logic [AW:0]   rgray,
   output logic [AW-1:0] raddr,
   output logic          rd_q,
   output logic          empty_n,
   output logic          aempty_n
);
   logic [AW:0] rbin_q, rbin_nx, wbin_s, level;
   logic        rd_fire;

   always_comb begin
      wbin_s[AW] = wgray_s[AW];
      for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign level    = wbin_s - rbin_q;
   assign empty_n  = (level != '0);
   assign aempty_n = (level > {1'b0, n_ofs});
   assign rd_fire  = !rd_en_n && empty_n;
   assign rbin_nx  = rbin_q + 1'b1;

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q <= '0;
         rgray  <= '0;
         rd_q   <= 1'b0;
      end else if (rd_fire) begin
         rbin_q <= rbin_nx;
         rgray  <= rbin_nx ^ (rbin_nx >> 1);
         rd_q   <= mem_bit;
      end
   end

   assign raddr = rbin_q[AW-1:0];
endmodule

// File: rtl/serial_fifo_dc.sv
module serial_fifo_dc #(
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       wr_clk,
   input  logic       rd_clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic       wen_a_n,
   input  logic       wen_b_ld,
   input  logic [7:0] ofs_in,
   input  logic       rd_en_n,
   input  logic       oe_n,
   output logic       dout,
   output logic       dout_en,
   output logic       full_n,
   output logic       afull_n,
   output logic       empty_n,
   output logic       aempty_n
);
   localparam int AW    = $clog2(DEPTH);
   localparam int PTR_W = AW + 1;

   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("serial_fifo_dc DEPTH must be a power of two of at least 16");
      end
   endgenerate

   logic             cfg_prog, wr_req, wr_fire, mem_bit, rd_q;
   logic [AW-1:0]    n_ofs, m_ofs, waddr, raddr;
   logic [PTR_W-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [DEPTH-1:0] store;

   sfifo_wport_cfg #(.OFS_W(AW)) u_cfg (
      .wr_clk(wr_clk), .rst_n(rst_n), .wen_a_n(wen_a_n), .wen_b_ld(wen_b_ld),
      .ofs_in(ofs_in), .prog_mode(cfg_prog), .wr_req(wr_req),
      .n_ofs(n_ofs), .m_ofs(m_ofs)
   );

   sfifo_wr_ctl #(.AW(AW)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_req(wr_req), .rgray_s(rgray_s),
      .m_ofs(m_ofs), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
      .full_n(full_n), .afull_n(afull_n)
   );

   sfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   sfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   sfifo_rd_ctl #(.AW(AW)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .wgray_s(wgray_s),
      .n_ofs(n_ofs), .mem_bit(mem_bit), .rgray(rgray), .raddr(raddr),
      .rd_q(rd_q), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   always_ff @(posedge wr_clk) begin
      if (wr_fire) store[waddr] <= din;
   end

   assign mem_bit = store[raddr];
   assign dout_en = !oe_n;
   assign dout    = dout_en & rd_q;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
   parameter int PW = 7
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wen_a_n,
   input logic          wen_b_ld,
   input logic          rd_en_n,
   input logic          cfg_prog,
   input logic          full_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic          rd_q,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rgray
);
   always @(negedge wr_clk) begin
      if (!rst_n) begin
         a_r1_reset_flags: assert (full_n && afull_n && !empty_n && !aempty_n && !rd_q)
            else $error("R1 reset state wrong");
      end
   end

   a_r3_dual_gate: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!cfg_prog && (wen_a_n || !wen_b_ld)) |=> $stable(wgray));

   a_r4_load_no_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (cfg_prog && !wen_b_ld) |=> $stable(wgray));

   a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> $stable(wgray));

   a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> ($stable(rgray) && $stable(rd_q)));

   a_r6_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_en_n |=> ($stable(rgray) && $stable(rd_q)));

   a_r8_empty_in_aempty: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   a_r9_full_in_afull: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   a_r13_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   a_r13_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind serial_fifo_dc sfifo_chk #(.PW(PTR_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wen_a_n(wen_a_n),
   .wen_b_ld(wen_b_ld), .rd_en_n(rd_en_n), .cfg_prog(cfg_prog),
   .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
   .rd_q(rd_q), .wgray(wgray), .rgray(rgray)
);

// File: tb/tb_serial_fifo_dc.sv
module tb_serial_fifo_dc;
   localparam int DEPTH = 64;

   logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b1;
   logic       din = 1'b0, wen_a_n = 1'b1, wen_b_ld = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
   logic [7:0] ofs_in = 8'h00;
   logic       dout, dout_en, full_n, afull_n, empty_n, aempty_n;

   int   checks = 0, fails = 0;
   logic q[$];
   logic rd_ok = 1'b0;
   logic exp_bit, held;
   int   edges;

   always #10 wr_clk = ~wr_clk;
   always #13 rd_clk = ~rd_clk;

   serial_fifo_dc #(.DEPTH(DEPTH)) dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
      .wen_a_n(wen_a_n), .wen_b_ld(wen_b_ld), .ofs_in(ofs_in), .rd_en_n(rd_en_n),
      .oe_n(oe_n), .dout(dout), .dout_en(dout_en), .full_n(full_n),
      .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic pat(input int i);
      return logic'(((i * 11) ^ (i >> 2)) & 1);
   endfunction

   // driver: one write-port cycle; the model pushes what the port must accept
   task automatic wr_cyc(input logic d, input logic a_n, input logic b);
      @(negedge wr_clk);
      din = d; wen_a_n = a_n; wen_b_ld = b;
      if (!a_n && b && full_n) q.push_back(d);
      @(posedge wr_clk); #2;
      wen_a_n = 1'b1; wen_b_ld = 1'b1;
   endtask

   task automatic load_ofs(input logic [7:0] v);
      @(negedge wr_clk);
      ofs_in = v; wen_a_n = 1'b0; wen_b_ld = 1'b0;
      @(posedge wr_clk); #2;
      wen_a_n = 1'b1; wen_b_ld = 1'b1;
   endtask

   task automatic rd_cyc();
      @(negedge rd_clk);
      rd_en_n = 1'b0; rd_ok = empty_n;
      @(posedge rd_clk); #5;
      rd_en_n = 1'b1;
   endtask

   // monitor: pops the expected bit when an accepted read lands
   always begin
      @(posedge rd_clk); #3;
      if (rst_n && !rd_en_n && rd_ok) begin
         if (q.size() == 0) check("R6 read with empty model", 1, 0);
         else begin
            exp_bit = q.pop_front();
            check("R6 data order", dout, exp_bit);
         end
      end
   end

   task automatic settle();
      repeat (4) @(posedge rd_clk);
      repeat (4) @(posedge wr_clk);
      #3;
   endtask

   task automatic do_reset(input logic dual);
      rst_n = 1'b0; wen_b_ld = dual; wen_a_n = 1'b1; rd_en_n = 1'b1; rd_ok = 1'b0;
      q.delete();
      repeat (3) @(posedge wr_clk); #3;
      check("R1 full_n in reset", full_n, 1);
      check("R1 afull_n in reset", afull_n, 1);
      check("R1 empty_n in reset", empty_n, 0);
      check("R1 aempty_n in reset", aempty_n, 0);
      check("R1 dout in reset", dout, 0);
      @(negedge wr_clk);
      rst_n = 1'b1; wen_b_ld = 1'b1;
      repeat (2) @(posedge rd_clk); #3;
   endtask

   initial begin
      #1;
      // dual-enable mode
      do_reset(1'b1);
      oe_n = 1'b1; #1;
      check("R12 dout_en off", dout_en, 0);
      oe_n = 1'b0; #1;
      check("R12 dout_en on", dout_en, 1);

      ofs_in = 8'd2;
      wr_cyc(1'b1, 1'b0, 1'b0);
      wr_cyc(1'b1, 1'b1, 1'b1);
      wr_cyc(1'b1, 1'b1, 1'b0);
      settle();
      check("R3 ignored enable combos", empty_n, 0);

      wr_cyc(pat(0), 1'b0, 1'b1);
      check("R11 empty_n not before read edge", empty_n, 0);
      edges = 0;
      for (int k = 0; k < 6; k++) begin
         @(posedge rd_clk); #3;
         edges++;
         if (empty_n) break;
      end
      check("R11 empty_n rise lag", (edges >= 1 && edges <= 3), 1);

      for (int i = 1; i < 3; i++) wr_cyc(pat(i), 1'b0, 1'b1);
      settle();
      check("R2 dual mode kept n=7", aempty_n, 0);
      check("R7 not empty", empty_n, 1);

      for (int i = q.size(); i < 7; i++) wr_cyc(pat(i), 1'b0, 1'b1);
      settle();
      check("R8 count 7 almost empty", aempty_n, 0);
      wr_cyc(pat(7), 1'b0, 1'b1);
      settle();
      check("R8 count 8 above n", aempty_n, 1);

      for (int i = q.size(); i < DEPTH - 8; i++) wr_cyc(pat(i), 1'b0, 1'b1);
      settle();
      check("R9 count 56 below threshold", afull_n, 1);
      wr_cyc(pat(56), 1'b0, 1'b1);
      check("R11 afull_n same edge", afull_n, 0);
      check("R9 count 57 almost full", afull_n, 0);

      for (int i = q.size(); i < DEPTH - 1; i++) wr_cyc(pat(i), 1'b0, 1'b1);
      settle();
      check("R7 count 63 not full", full_n, 1);
      wr_cyc(pat(63), 1'b0, 1'b1);
      check("R11 full_n same edge", full_n, 0);
      wr_cyc(1'b1, 1'b0, 1'b1);
      wr_cyc(1'b0, 1'b0, 1'b1);
      check("R5 full after overflow attempts", full_n, 0);

      rd_cyc();
      held = dout;
      repeat (3) @(posedge rd_clk); #3;
      check("R6 output holds when idle", dout, held);
      oe_n = 1'b1; #1;
      check("R12 dout low when not driven", dout, 0);
      check("R12 dout_en low", dout_en, 0);
      oe_n = 1'b0; #1;
      check("R12 dout restored", dout, held);

      repeat (7) rd_cyc();
      settle();
      check("R9 count 56 afull released", afull_n, 1);
      check("R7 full released", full_n, 1);

      while (q.size() > 0) rd_cyc();
      #4;
      check("R5 no extra bits stored", empty_n, 0);
      check("R8 empty also almost empty", aempty_n, 0);
      held = dout;
      rd_cyc();
      check("R5 underflow holds dout", dout, held);
      check("R5 still empty", empty_n, 0);

      // programming mode
      do_reset(1'b0);
      load_ofs(8'd2);
      wr_cyc(pat(0), 1'b0, 1'b1);
      load_ofs(8'd60);
      for (int i = 1; i < 4; i++) wr_cyc(pat(i), 1'b0, 1'b1);
      settle();
      check("R10 n loaded to 2", aempty_n, 1);
      check("R10 m loaded to 60", afull_n, 0);
      check("R4 writes stored", empty_n, 1);
      load_ofs(8'd5);
      settle();
      check("R10 rotation wraps to n", aempty_n, 0);
      check("R10 m unchanged", afull_n, 0);
      for (int i = 0; i < 4; i++) rd_cyc();
      #4;
      check("R4 loads stored no bit", empty_n, 0);

      // concurrent traffic in dual-enable mode
      do_reset(1'b1);
      fork
         begin
            for (int i = 0; i < 50; i++) wr_cyc(pat(i + 3), 1'b0, 1'b1);
         end
         begin
            repeat (140) rd_cyc();
         end
      join
      settle();
      check("R6 all bits delivered", q.size(), 0);
      check("R7 empty after drain", empty_n, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule